// File: doc/BRIEF.md
# Glitch-Free Divided Clock Output Gate

This block takes a master clock, divides it by a power of two chosen by a 3-bit code, and drives the result onto an output pin. An asynchronous enable input controls the pin. A high-impedance select bit picks what the pin does while it is disabled: it either parks low or floats. The output level and a separate drive-enable signal together model a tri-state pad.

Turning the output on is synchronized to the master clock. The output starts at the beginning of a high phase, so the first pulse always has full width. Turning it off is combinational from the enable pin, so it acts without waiting for a clock edge and may cut a high pulse short.

Start-up logic resolves the divide code and signals this with a valid flag. The output stays disabled until that flag is seen. The code present on that cycle is captured and held until the next reset.

Top module: `oscOutGate`

## Requirements
- R1: During reset and right after it, outLevel is 0 and outDrive equals the inverse of hiZSel.
- R2: Until codeValid has been high on a rising clock edge after reset, outLevel stays 0 even with enIn high. The divCode sampled on that edge is kept, and later changes to divCode have no effect on the output rate until the next reset.
- R3: While enabled with captured code k from 1 to 7, outLevel repeats with a period of 2^k master cycles. Each period is high for the first 2^(k-1) cycles and low for the rest.
- R4: While enabled with captured code 0, outLevel equals the master clock level.
- R5: After enIn rises while the block is ready, outLevel is still 0 after the first rising clock edge and becomes active at the second rising edge.
- R6: The first high pulse after enabling lasts a full half period (2^(k-1) master cycles for k of 1 or more).
- R7: When enIn falls, outLevel goes to 0 at once, with no clock edge needed, even in the middle of a high pulse.
- R8: While enIn is 0, outDrive is 0 if hiZSel is 1. If hiZSel is 0, outDrive is 1 and outLevel is 0.
- R9: While enIn is 1 and the block is ready, outDrive is 1 whatever the value of hiZSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Asynchronous output enable |
| hiZSel | input | 1 | 1: float the pin while disabled; 0: drive it low |
| codeValid | input | 1 | Divide code has been resolved |
| divCode | input | 3 | Divide ratio code k, ratio 2^k |
| outLevel | output | 1 | Output pin level |
| outDrive | output | 1 | Pad drive enable (0 means high impedance) |

## Verification
The main function is tried with the slow ratios 4 and 128, the fastest divided ratio 2, and the undivided ratio where the output follows the clock. Between them, these tell a wrong period from a wrong duty split, and a wrong bit select from a correct counter. Enables are applied with hiZSel at both values, and the divCode changes after capture must leave the period alone. An enable dropped in the middle of a high pulse must zero the output before any edge. A re-enable must then give a full first pulse after exactly two edges, which exposes both a missing synchronizer stage and a counter that is not restarted.

// File: rtl/oscGatePkg.sv
package oscGatePkg;
  localparam int DIV_CODE_W = 3;

  typedef struct packed {
    logic                  run;
    logic [DIV_CODE_W-1:0] ratioCode;
  } gateStrobe_t;
endpackage

// File: rtl/oscGateCtrl.sv
module oscGateCtrl
  import oscGatePkg::*;
#(
  parameter int CODE_W = DIV_CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] divCode,
  output gateStrobe_t       strobe,
  output logic              ready
);
  logic              readyQ;
  logic [CODE_W-1:0] codeQ;
  logic              syncA;
  logic              syncB;
  logic              clrN;

  assign clrN = rstN & enIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      codeQ  <= '0;
    end else if (!readyQ && codeValid) begin
      readyQ <= 1'b1;
      codeQ  <= divCode;
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= readyQ;
      syncB <= syncA;
    end
  end

  assign ready           = readyQ;
  assign strobe.run      = syncB;
  assign strobe.ratioCode = codeQ;

  // R5: run only starts after the enable was seen on the previous edge too
  assert_run_after_two_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.run) |-> (enIn && $past(enIn) && readyQ));

  // R2: captured code never moves once ready
  assert_code_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(readyQ) && readyQ) |-> $stable(codeQ));
endmodule

// File: rtl/oscGateDatapath.sv
module oscGateDatapath
  import oscGatePkg::*;
#(
  parameter int CODE_W = DIV_CODE_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  output logic        phaseOut
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntMask;
  logic [CNT_W-1:0] shifted;
  logic             halfHigh;

  assign cntMask  = ~({CNT_W{1'b1}} << strobe.ratioCode);
  assign shifted  = cnt >> (strobe.ratioCode - 1'b1);
  assign halfHigh = (strobe.ratioCode == '0) ? clk : ~shifted[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!strobe.run) begin
      cnt <= '0;
    end else begin
      cnt <= (cnt + 1'b1) & cntMask;
    end
  end

  assign phaseOut = strobe.run & halfHigh;

  // R6: divider starts from zero, i.e. at the head of a high phase
  assert_first_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.run) |-> (cnt == '0));

  // R3: counter stays inside the selected ratio
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt & ~cntMask) == '0));
endmodule

// File: rtl/oscOutGate.sv
module oscOutGate
  import oscGatePkg::*;
#(
  parameter int CODE_W = DIV_CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic              hiZSel,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] divCode,
  output logic              outLevel,
  output logic              outDrive
);
  gateStrobe_t strobe;
  logic        ready;
  logic        phaseOut;

  oscGateCtrl #(.CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .codeValid(codeValid),
    .divCode(divCode), .strobe(strobe), .ready(ready)
  );

  oscGateDatapath #(.CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phaseOut(phaseOut)
  );

  assign outLevel = enIn & phaseOut;
  assign outDrive = (enIn & ready) | ~hiZSel;

  assert_disable_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |-> !outLevel);

  assert_hiz_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enIn && hiZSel) |-> !outDrive);

  assert_wait_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !outLevel);

  assert_drive_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && ready) |-> outDrive);
endmodule

// File: tb/sim_oscOutGate.sv
`timescale 1ns/1ps
module sim_oscOutGate;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enIn = 1'b0;
  logic       hiZSel = 1'b1;
  logic       codeValid = 1'b0;
  logic [2:0] divCode = 3'd3;
  logic       outLevel;
  logic       outDrive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mReady = 0;
  int mCode = 0;
  int mCnt = 0;

  oscOutGate u0 (
    .clk(clk), .rstN(rstN), .enIn(enIn), .hiZSel(hiZSel),
    .codeValid(codeValid), .divCode(divCode),
    .outLevel(outLevel), .outDrive(outDrive)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // behavioural reference, compared on every clock
  always @(posedge clk) begin
    logic expLvl;
    logic expDrv;
    int   n;
    string tag;
    if (!rstN) begin
      mReady = 0; mCode = 0; mCnt = 0;
    end else begin
      if (enIn && mReady != 0) mCnt++;
      else mCnt = 0;
      if (mReady == 0 && codeValid) begin
        mReady = 1;
        mCode = int'(divCode);
      end
    end
    #5;
    n = 1 << mCode;
    expLvl = enIn && (mCnt >= 2) &&
             ((mCode == 0) ? 1'b1 : (((mCnt - 2) % n) < n / 2));
    expDrv = (enIn && mReady != 0) || !hiZSel;
    if (!rstN) tag = "R1";
    else if (!enIn) tag = "R8";
    else if (mReady == 0) tag = "R2";
    else if (mCode == 0) tag = "R4";
    else tag = "R3";
    if (!done) begin
      chk({tag, " level"}, outLevel, expLvl);
      chk((enIn && mReady != 0) ? "R9 drive" : {tag, " drive"}, outDrive, expDrv);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input logic [2:0] code);
    @(negedge clk);
    rstN = 1'b0; enIn = 1'b0; codeValid = 1'b0;
    cycles(2);
    rstN = 1'b1;
    cycles(1);
    divCode = code; codeValid = 1'b1;
    cycles(1);
    codeValid = 1'b0; divCode = ~code;
    cycles(1);
  endtask

  initial begin
    // R1: reset state with both pad modes
    cycles(2);
    #1 chk("R1 level", outLevel, 1'b0);
    chk("R1 drive hiZ", outDrive, 1'b0);
    hiZSel = 1'b0;
    #1 chk("R1 drive low", outDrive, 1'b1);
    cycles(1);
    rstN = 1'b1;
    // R2: enabled but code not yet valid
    enIn = 1'b1;
    cycles(6);
    #1 chk("R2 waiting", outLevel, 1'b0);
    divCode = 3'd2; codeValid = 1'b1;
    cycles(1);
    codeValid = 1'b0; divCode = 3'd5;   // R2: late change ignored
    cycles(20);
    // R8: disable in both modes
    enIn = 1'b0; hiZSel = 1'b1;
    #1 chk("R8 float", outDrive, 1'b0);
    hiZSel = 1'b0;
    #1 chk("R8 drive", outDrive, 1'b1);
    chk("R8 low", outLevel, 1'b0);
    hiZSel = 1'b1;
    cycles(3);
    // R5 / R6 / R9: enable latency and first pulse (ratio 4)
    enIn = 1'b1;
    #1 chk("R9 drive", outDrive, 1'b1);
    @(posedge clk); #5 chk("R5 edge1", outLevel, 1'b0);
    @(posedge clk); #5 chk("R5 edge2", outLevel, 1'b1);
    @(posedge clk); #5 chk("R6 width", outLevel, 1'b1);
    @(posedge clk); #5 chk("R6 end", outLevel, 1'b0);
    cycles(10);
    // R7: drop enable in the middle of a high pulse
    while (1) begin
      @(posedge clk); #5;
      if (outLevel) break;
    end
    #3 enIn = 1'b0;
    #1 chk("R7 immediate", outLevel, 1'b0);
    cycles(3);
    enIn = 1'b1;
    cycles(16);
    // R4: undivided output follows the clock
    restart(3'd0);
    enIn = 1'b1;
    cycles(4);
    @(posedge clk); #5 chk("R4 high", outLevel, 1'b1);
    @(negedge clk); #5 chk("R4 low", outLevel, 1'b0);
    cycles(8);
    // R3: largest and smallest divided ratios
    restart(3'd7);
    enIn = 1'b1;
    cycles(300);
    restart(3'd1);
    hiZSel = 1'b0;
    enIn = 1'b1;
    cycles(12);
    enIn = 1'b0;
    cycles(2);
    enIn = 1'b1;
    cycles(12);
    done = 1'b1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog at %0t: actual hung expected finished", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule